// File: doc/BRIEF.md
# Bidirectional Parity Bus Transceiver

This block moves one data word between two ports, A and B, in a direction chosen by a select input. A parity pin travels with the word. When the block sends from A to B, it produces the parity pin from the word on A. When it receives from B to A, the parity pin is an input, and the block checks it against the word on B. An odd/even select picks the parity sense. A parity mismatch pulls an active-low error flag down.

The block is purely combinational and has no clock. Each pin that can be driven from either side appears as three separate signals: an input, an output value and an output enable. The pad ring or a tri-state wrapper turns these into real bus pins. An active-low enable releases every driven pin at once. The port pins carry raw data with no valid/ready handshake, because the block has no storage and cannot apply back-pressure. Whatever stands on the input side appears on the output side in the same instant.

Top module: `parity_bus_xcvr`

## Requirements
- R1: With `dir_tx`=1 and `oe_n`=0, `b_oe`=1, `a_oe`=0 and `b_out` equals `a_in` bit for bit.
- R2: With `dir_tx`=0 and `oe_n`=0, `a_oe`=1, `b_oe`=0 and `a_out` equals `b_in` bit for bit.
- R3: With `oe_n`=1, `a_oe`, `b_oe` and `par_oe` are all 0 and `err_n` is 1, whatever the other inputs are.
- R4: With `dir_tx`=1 and `oe_n`=0, `par_oe`=1 and `par_out` is set as follows. The number of ones in `a_in` plus `par_out` is even when `odd_sel`=0 and odd when `odd_sel`=1.
- R5: With `dir_tx`=0 and `oe_n`=0, `par_oe`=0. `err_n` is 0 exactly when the number of ones in `b_in` plus `par_in` does not match the sense chosen by `odd_sel` (even for 0, odd for 1).
- R6: In transmit mode, `err_n` stays 1 for every value of `b_in` and `par_in`.
- R7: `a_oe` and `b_oe` are never 1 together.
- R8: Inputs on the receiving side have no effect. In transmit mode, `b_in` and `par_in` do not change `b_out` or `par_out`. In receive mode, `a_in` does not change `a_out` or `err_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| a_in | input | DATA_W | Value seen on the A pins |
| a_out | output | DATA_W | Value to drive onto the A pins |
| a_oe | output | 1 | Drive enable for the A pins |
| b_in | input | DATA_W | Value seen on the B pins |
| b_out | output | DATA_W | Value to drive onto the B pins |
| b_oe | output | 1 | Drive enable for the B pins |
| par_in | input | 1 | Value seen on the parity pin |
| par_out | output | 1 | Generated parity to drive onto the parity pin |
| par_oe | output | 1 | Drive enable for the parity pin |
| dir_tx | input | 1 | 1: send A to B; 0: receive B to A |
| oe_n | input | 1 | Active-low enable for all drivers |
| odd_sel | input | 1 | 1: odd parity; 0: even parity |
| err_n | output | 1 | Active-low parity error, valid in receive mode |

## Verification
The embedded checks assume that every input holds a defined 0/1 level whenever the outputs are evaluated. They also assume that the external tri-state wrapper honours the enables, so that a released pin never feeds the block's own output back as an input. The stimulus meets both conditions. It changes the inputs only at a clock edge and keeps them stable until the result is sampled half a period later. To exercise R8, it puts deliberately different values on the receiving side's inputs.

// File: rtl/ptx_pkg.sv
package ptx_pkg;
  typedef enum logic {
    PTX_RX = 1'b0,
    PTX_TX = 1'b1
  } ptx_dir_e;

  typedef enum logic {
    PTX_EVEN = 1'b0,
    PTX_ODD  = 1'b1
  } ptx_sense_e;
endpackage

// File: rtl/ptx_xor_tree.sv
module ptx_xor_tree #(
  parameter int W = 8
) (
  input  logic [W-1:0] data_i,
  output logic         odd_o
);
  localparam int LVL   = (W > 1) ? $clog2(W) : 0;
  localparam int LEAVES = 1 << LVL;
  localparam int NODES  = 2 * LEAVES - 1;
  localparam int FIRST_LEAF = LEAVES - 1;

  logic [NODES-1:0] node;

  genvar gi;
  generate
    for (gi = 0; gi < LEAVES; gi++) begin : g_leaf
      if (gi < W) begin : g_real
        assign node[FIRST_LEAF + gi] = data_i[gi];
      end else begin : g_pad
        assign node[FIRST_LEAF + gi] = 1'b0;
      end
    end
    for (gi = 0; gi < FIRST_LEAF; gi++) begin : g_inner
      assign node[gi] = node[2*gi+1] ^ node[2*gi+2];
    end
  endgenerate

  assign odd_o = node[0];
endmodule

// File: rtl/ptx_dir_ctrl.sv
module ptx_dir_ctrl
  import ptx_pkg::*;
(
  input  ptx_dir_e dir_i,
  input  logic     oe_n_i,
  output logic     a_oe_o,
  output logic     b_oe_o,
  output logic     par_oe_o,
  output logic     chk_en_o
);
  logic live;

  always_comb begin
    live     = ~oe_n_i;
    a_oe_o   = live && (dir_i == PTX_RX);
    b_oe_o   = live && (dir_i == PTX_TX);
    par_oe_o = b_oe_o;
    chk_en_o = a_oe_o;
  end
endmodule

// File: rtl/parity_bus_xcvr.sv
module parity_bus_xcvr
  import ptx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a_in,
  output logic [DATA_W-1:0] a_out,
  output logic              a_oe,
  input  logic [DATA_W-1:0] b_in,
  output logic [DATA_W-1:0] b_out,
  output logic              b_oe,
  input  logic              par_in,
  output logic              par_out,
  output logic              par_oe,
  input  logic              dir_tx,
  input  logic              oe_n,
  input  logic              odd_sel,
  output logic              err_n
);
  logic a_odd, b_odd, chk_en;
  ptx_dir_e   dir;
  ptx_sense_e sense;

  assign dir   = ptx_dir_e'(dir_tx);
  assign sense = ptx_sense_e'(odd_sel);

  ptx_dir_ctrl u_ctrl (
    .dir_i   (dir),
    .oe_n_i  (oe_n),
    .a_oe_o  (a_oe),
    .b_oe_o  (b_oe),
    .par_oe_o(par_oe),
    .chk_en_o(chk_en)
  );

  ptx_xor_tree #(.W(DATA_W)) u_gen (
    .data_i(a_in),
    .odd_o (a_odd)
  );

  ptx_xor_tree #(.W(DATA_W)) u_chk (
    .data_i(b_in),
    .odd_o (b_odd)
  );

  always_comb begin
    b_out   = a_in;
    a_out   = b_in;
    par_out = a_odd ^ (sense == PTX_ODD);
    err_n   = chk_en ? ((b_odd ^ par_in) == (sense == PTX_ODD)) : 1'b1;
  end

  always_comb begin
    p_one_side_r7: assert ($onehot0({a_oe, b_oe}));
    if (oe_n) begin
      p_released_r3: assert (!a_oe && !b_oe && !par_oe && err_n);
    end
    if (par_oe) begin
      p_tx_sense_r4: assert ((^{b_out, par_out}) == odd_sel);
      p_quiet_err_r6: assert (err_n);
    end
    if (a_oe) begin
      p_rx_copy_r2: assert (a_out == b_in && !par_oe);
    end
    if (b_oe) begin
      p_tx_copy_r1: assert (b_out == a_in);
    end
  end
endmodule

// File: tb/parity_bus_xcvr_tb.sv
module parity_bus_xcvr_tb;
  localparam int W = 8;

  typedef struct {
    logic         a_oe, b_oe, par_oe, err_n;
    logic [W-1:0] a_out, b_out;
    logic         par_out;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [W-1:0] a_in = '0, b_in = '0, a_out, b_out;
  logic a_oe, b_oe, par_in = 1'b0, par_out, par_oe;
  logic dir_tx = 1'b0, oe_n = 1'b1, odd_sel = 1'b0, err_n;

  int total = 0, bad = 0;
  bit done = 1'b0;
  exp_t q[$];

  parity_bus_xcvr #(.DATA_W(W)) u_dut (
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe),
    .par_in(par_in), .par_out(par_out), .par_oe(par_oe),
    .dir_tx(dir_tx), .oe_n(oe_n), .odd_sel(odd_sel), .err_n(err_n)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [W-1:0] a, input logic [W-1:0] b, input logic p,
                       input logic d, input logic oen, input logic odd);
    exp_t e;
    int   ones;
    @(posedge clk);
    a_in = a; b_in = b; par_in = p; dir_tx = d; oe_n = oen; odd_sel = odd;
    e.a_oe   = !oen && !d;
    e.b_oe   = !oen && d;
    e.par_oe = !oen && d;
    e.a_out  = b;
    e.b_out  = a;
    ones     = $countones(a);
    e.par_out = ((ones % 2) == 1) ^ odd;
    ones     = $countones(b) + int'(p);
    e.err_n  = (oen || d) ? 1'b1 : (((ones % 2) == 1) == odd);
    q.push_back(e);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      chk(a_oe == e.a_oe, "R2/R3 a_oe", int'(a_oe), int'(e.a_oe));
      chk(b_oe == e.b_oe, "R1/R3 b_oe", int'(b_oe), int'(e.b_oe));
      chk(par_oe == e.par_oe, "R4/R3 par_oe", int'(par_oe), int'(e.par_oe));
      chk(!(a_oe && b_oe), "R7 both enabled", int'({a_oe, b_oe}), 0);
      chk(err_n == e.err_n, "R5/R6 err_n", int'(err_n), int'(e.err_n));
      if (e.a_oe) chk(a_out == e.a_out, "R2/R8 a_out", int'(a_out), int'(e.a_out));
      if (e.b_oe) chk(b_out == e.b_out, "R1/R8 b_out", int'(b_out), int'(e.b_out));
      if (e.par_oe) chk(par_out == e.par_out, "R4/R8 par_out", int'(par_out), int'(e.par_out));
    end
  end

  initial begin
    #5;
    chk(!a_oe && !b_oe && !par_oe && err_n, "R3 reset state",
        int'({a_oe, b_oe, par_oe, err_n}), 1);
    repeat (3) @(posedge clk);
    rst_n = 1'b1;
    drive(8'h1F, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0);
    drive(8'h00, 8'h07, 1'b1, 1'b0, 1'b0, 1'b1);
    drive(8'h00, 8'h07, 1'b0, 1'b0, 1'b0, 1'b1);
    for (int v = 0; v < 256; v++) begin
      for (int m = 0; m < 16; m++) begin
        logic d, oen, odd, p;
        logic [W-1:0] a, b;
        d = m[0]; odd = m[1]; p = m[2]; oen = m[3];
        a = d ? W'(v) : ~W'(v);
        b = d ? ~W'(v) ^ W'(m) : W'(v);
        drive(a, b, p, d, oen, odd);
      end
    end
    drive(8'hA5, 8'h5A, 1'b1, 1'b1, 1'b1, 1'b1);
    @(posedge clk);
    @(posedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (200000) @(posedge clk);
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule